// File: doc/BRIEF.md
# Audio Soft Mute and Zero-Run Detector

This block sits in the per-sample path of a two-channel audio converter front end. Each accepted input beat carries one signed 24-bit left sample and one signed 24-bit right sample. The block scales both samples by a shared linear gain and passes them on. When the mute request changes, the gain ramps one step per accepted sample. A full swing between unity and silence therefore takes exactly `RAMP_LEN` samples. If the request flips while a ramp is in progress, the gain turns around from the level it had reached.

Alongside the gain path, a run detector counts consecutive beats on which both channels carry zero. Once the run reaches `ZRUN_LEN` beats, it raises a zero flag. The flag is pinned high while the timing-reset input is active and stays high for `REL_HOLD` beats after that input drops. It is pinned low during power-down.

Samples enter and leave through valid/ready streams. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when power-down is inactive and the output register is empty or being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output data holds still and no new input is taken.

Top module: `audio_mute_zdet`

## Requirements
- R1: With the gain at unity and `mute_req` high, the k-th accepted beat (k counted from 0) leaves scaled by (1024-k)/1024, using an arithmetic shift right by 10. From beat 1024 onward the output is zero.
- R2: With the gain at zero and `mute_req` low, the k-th accepted beat is scaled by k/1024. From beat 1024 onward the output equals the input exactly.
- R3: When `mute_req` drops part-way through a down-ramp, the next beat uses the level that had been reached. From there the gain rises one step per beat until it reaches unity.
- R4: At unity gain every sample, including both extreme values, passes through unchanged, and one output beat appears one cycle after each accepted input beat.
- R5: `zero_flag` rises after the 8192nd consecutive accepted beat on which both channels are zero. It is still low after the 8191st. It stays high on further zero beats.
- R6: An accepted beat with either channel nonzero lowers `zero_flag` in the next cycle and restarts the run count from zero.
- R7: While `tim_rst` is high, `zero_flag` is high and accepted beats leave as zero. After `tim_rst` falls, the flag stays high through 3 more accepted beats and is low after the 4th.
- R8: While `pdn` is high, `zero_flag` and `in_ready` are low and `out_valid` clears. On release, the gain sits at the level that matches `mute_req`, and the run count is zero.
- R9: While the gain is zero, every output sample is exactly zero, whether the input is zero or not.
- R10: While `out_valid` is high and `out_ready` is low, the output data stays stable and `in_ready` is low. The waiting beat is taken on the first cycle with `out_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn | input | 1 | Power-down, synchronous, active high |
| tim_rst | input | 1 | Internal timing reset, synchronous, active high |
| mute_req | input | 1 | Soft mute request level |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the output beat |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| zero_flag | output | 1 | Both channels have been zero for a long run |

## Verification
The bench follows the full 1025-beat ramps in both directions and a reversal at beat 300. An off-by-one in the step counter would show up there as a final beat that is not zero or not exact. A design that restarts the ramp from unity or from zero instead of the reached level would show up as a jump in the output. The zero run is probed at 8191 and at 8192 beats, and it is broken by each channel on its own. A detector that looks at only one channel, or that fails to saturate, would leave the flag wrong. The timing-reset release is checked beat by beat. The bench also checks that a power-down clears the partly ramped gain, and that a stalled output keeps its data and does not lose the waiting input.

// File: rtl/amzd_pkg.sv
package amzd_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CHANNELS = 2;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef sample_t [CHANNELS-1:0] frame_t;
endpackage

// File: rtl/mute_gain_ramp.sv
module mute_gain_ramp #(
  parameter int RAMP_LEN = 1024,
  localparam int GW = $clog2(RAMP_LEN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mute,
  input  logic          step,
  output logic [GW-1:0] gain
);
  localparam logic [GW-1:0] UNITY = GW'(RAMP_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain <= UNITY;
    end else if (clr) begin
      gain <= mute ? '0 : UNITY;
    end else if (step) begin
      if (mute && gain != '0)           gain <= gain - 1'b1;
      else if (!mute && gain != UNITY)  gain <= gain + 1'b1;
    end
  end

  // R1 R2 R3
  gain_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(clr) |->
      (gain == $past(gain)) || (gain == $past(gain) + 1'b1) || (gain + 1'b1 == $past(gain)));

  // R2
  gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= UNITY);
endmodule

// File: rtl/sample_scaler.sv
module sample_scaler
  import amzd_pkg::*;
#(
  parameter int GW = 11,
  parameter int SHIFT = 10,
  localparam int PW = SAMPLE_W + GW + 1
) (
  input  frame_t        din,
  input  logic [GW-1:0] gain,
  output frame_t        dout
);
  logic signed [PW-1:0] gain_s;
  assign gain_s = PW'($signed({1'b0, gain}));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic signed [PW-1:0] prod;
    assign prod    = PW'(din[c]) * gain_s;
    assign dout[c] = SAMPLE_W'(prod >>> SHIFT);
  end
endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
  parameter int ZRUN_LEN = 8192,
  parameter int REL_HOLD = 4,
  localparam int CW = $clog2(ZRUN_LEN + 1),
  localparam int HW = $clog2(REL_HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn,
  input  logic tim_rst,
  input  logic step,
  input  logic both_zero,
  output logic zflag
);
  localparam logic [CW-1:0] RUN_MAX = CW'(ZRUN_LEN);
  localparam logic [HW-1:0] HOLD_MAX = HW'(REL_HOLD);

  logic [CW-1:0] run_cnt;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      hold_cnt <= '0;
    end else if (pdn) begin
      run_cnt  <= '0;
      hold_cnt <= '0;
    end else if (tim_rst) begin
      run_cnt  <= '0;
      hold_cnt <= HOLD_MAX;
    end else if (step) begin
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (!both_zero)             run_cnt <= '0;
      else if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign zflag = !pdn && (tim_rst || hold_cnt != '0 || run_cnt == RUN_MAX);

  // R5
  run_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_MAX);

  // R6
  nonzero_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !both_zero && !pdn |=> run_cnt == '0);

  // R7
  release_holds_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tim_rst) && !pdn |-> zflag);
endmodule

// File: rtl/audio_mute_zdet.sv
module audio_mute_zdet
  import amzd_pkg::*;
#(
  parameter int RAMP_LEN = 1024,
  parameter int ZRUN_LEN = 8192,
  parameter int REL_HOLD = 4,
  localparam int GW = $clog2(RAMP_LEN) + 1,
  localparam int SHIFT = $clog2(RAMP_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pdn,
  input  logic                tim_rst,
  input  logic                mute_req,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                zero_flag
);
  logic          step;
  logic [GW-1:0] gain;
  frame_t        din, scaled, dreg;

  assign in_ready = !pdn && (!out_valid || out_ready);
  assign step     = in_valid && in_ready;
  assign din[0]   = sample_t'(in_left);
  assign din[1]   = sample_t'(in_right);

  mute_gain_ramp #(.RAMP_LEN(RAMP_LEN)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(pdn || tim_rst), .mute(mute_req),
    .step(step), .gain(gain)
  );

  sample_scaler #(.GW(GW), .SHIFT(SHIFT)) u_scale (
    .din(din), .gain(gain), .dout(scaled)
  );

  zero_run_detect #(.ZRUN_LEN(ZRUN_LEN), .REL_HOLD(REL_HOLD)) u_zdet (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .tim_rst(tim_rst), .step(step),
    .both_zero(in_left == '0 && in_right == '0), .zflag(zero_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dreg      <= '0;
    end else if (pdn) begin
      out_valid <= 1'b0;
      dreg      <= '0;
    end else if (step) begin
      out_valid <= 1'b1;
      dreg      <= tim_rst ? '0 : scaled;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_left  = dreg[0];
  assign out_right = dreg[1];

  // R10
  stall_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !pdn |=> out_valid && $stable(out_left) && $stable(out_right));

  // R9
  muted_is_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && gain == '0 && !pdn |=> out_left == '0 && out_right == '0);

  // R8
  powerdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |-> !zero_flag && !in_ready);
endmodule

// File: tb/audio_mute_zdet_tb_top.sv
module audio_mute_zdet_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {in_left, in_right, expected_left, expected_right} at unity gain
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 0, 0},
    '{1, -1, 1, -1},
    '{8388607, -8388608, 8388607, -8388608},
    '{-8388608, 8388607, -8388608, 8388607},
    '{123456, -654321, 123456, -654321},
    '{-1, 1, -1, 1},
    '{4194304, 0, 4194304, 0},
    '{0, -77, 0, -77}
  };

  logic clk = 0, rst_n = 0, pdn = 0, tim_rst = 0, mute_req = 0;
  logic in_valid = 0, out_ready = 1;
  logic [23:0] in_left = '0, in_right = '0;
  logic in_ready, out_valid, zero_flag;
  logic [23:0] out_left, out_right;
  int checks = 0, failures = 0;
  int got_l, got_r;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_mute_zdet dut_i (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .tim_rst(tim_rst), .mute_req(mute_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
    .out_right(out_right), .zero_flag(zero_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic send(input int l, input int r);
    in_left  = l[23:0];
    in_right = r[23:0];
    in_valid = 1;
    @(negedge clk);
    got_l = $signed(out_left);
    got_r = $signed(out_right);
    in_valid = 0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R8 reset zero_flag", zero_flag, 0);
    chk("R8 reset out_valid", out_valid, 0);
    chk("R10 reset in_ready", in_ready, 1);

    // R4 vector walk at unity gain
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][0], VEC[i][1]);
      chk("R4 unity left", got_l, VEC[i][2]);
      chk("R4 unity right", got_r, VEC[i][3]);
      chk("R4 out_valid", out_valid, 1);
    end

    // R1 down-ramp
    mute_req = 1;
    bad = 0;
    for (int k = 0; k <= 1024; k++) begin
      send(4194304, -4194304);
      if (got_l != 4096*(1024-k) || got_r != -4096*(1024-k)) begin
        bad++;
        $display("FAIL R1 beat %0d actual=%0d expected=%0d", k, got_l, 4096*(1024-k));
      end
    end
    chk("R1 ramp mismatches", bad, 0);

    // R9 muted output silent
    send(0, 0);
    chk("R9 muted zero in left", got_l, 0);
    send(8388607, -8388608);
    chk("R9 muted full scale left", got_l, 0);
    chk("R9 muted full scale right", got_r, 0);

    // R2 up-ramp
    mute_req = 0;
    bad = 0;
    for (int k = 0; k <= 1025; k++) begin
      send(4194304, -4194304);
      if (got_l != 4096*(k > 1024 ? 1024 : k) || got_r != -4096*(k > 1024 ? 1024 : k)) begin
        bad++;
        $display("FAIL R2 beat %0d actual=%0d expected=%0d", k, got_l, 4096*k);
      end
    end
    chk("R2 ramp mismatches", bad, 0);

    // R3 reversal after 300 muted beats
    mute_req = 1;
    for (int k = 0; k < 300; k++) send(4194304, 0);
    chk("R3 level before release", got_l, 4096*725);
    mute_req = 0;
    bad = 0;
    for (int j = 0; j <= 301; j++) begin
      send(4194304, 0);
      if (got_l != 4096*((724 + j) > 1024 ? 1024 : (724 + j))) begin
        bad++;
        $display("FAIL R3 beat %0d actual=%0d expected=%0d", j, got_l, 4096*(724 + j));
      end
    end
    chk("R3 reversal mismatches", bad, 0);

    // R5 / R6 zero runs
    send(5, 5);
    for (int k = 0; k < 8191; k++) send(0, 0);
    chk("R5 flag low at 8191", zero_flag, 0);
    send(0, 0);
    chk("R5 flag high at 8192", zero_flag, 1);
    for (int k = 0; k < 5; k++) send(0, 0);
    chk("R5 flag stays high", zero_flag, 1);
    send(3, 0);
    chk("R6 left nonzero clears", zero_flag, 0);
    for (int k = 0; k < 8191; k++) send(0, 0);
    chk("R6 run restarted", zero_flag, 0);
    send(0, 0);
    chk("R5 flag high again", zero_flag, 1);
    send(0, -2);
    chk("R6 right nonzero clears", zero_flag, 0);

    // R7 timing reset
    tim_rst = 1;
    #1;
    chk("R7 flag forced high", zero_flag, 1);
    send(1000, -1000);
    chk("R7 output zero in reset left", got_l, 0);
    chk("R7 output zero in reset right", got_r, 0);
    tim_rst = 0;
    #1;
    chk("R7 flag high at release", zero_flag, 1);
    for (int k = 0; k < 3; k++) send(77, 77);
    chk("R7 flag high after 3 beats", zero_flag, 1);
    send(77, 77);
    chk("R7 flag low after 4 beats", zero_flag, 0);
    chk("R7 output restored", got_l, 77);

    // R8 power-down
    for (int k = 0; k < 8192; k++) send(0, 0);
    chk("R8 flag high before pdn", zero_flag, 1);
    mute_req = 1;
    for (int k = 0; k < 10; k++) send(4194304, 0);
    pdn = 1;
    #1;
    chk("R8 flag low in pdn", zero_flag, 0);
    chk("R8 in_ready low in pdn", in_ready, 0);
    mute_req = 0;
    repeat (3) @(negedge clk);
    chk("R8 out_valid cleared", out_valid, 0);
    pdn = 0;
    send(4194304, 0);
    chk("R8 gain back at unity", got_l, 4194304);
    chk("R8 run count cleared", zero_flag, 0);

    // R10 back-pressure
    @(negedge clk);
    chk("R10 idle out_valid", out_valid, 0);
    out_ready = 0;
    send(111, 222);
    chk("R10 first beat valid", out_valid, 1);
    in_left = 24'd333;
    in_right = 24'd444;
    in_valid = 1;
    #1;
    chk("R10 in_ready low on stall", in_ready, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 held left", $signed(out_left), 111);
    chk("R10 held right", $signed(out_right), 222);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R10 next beat left", $signed(out_left), 333);
    chk("R10 next beat right", $signed(out_right), 444);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule